// File: doc/BRIEF.md
# Serial Configuration Memory Loader with Software Bypass

This block fetches a small set of configuration words from an external serial EEPROM of the three-wire Microwire type as soon as reset is released. It reads a signature word first. If that word shows the part holds valid contents, the block reads a fixed number of configuration words, starting at word address 0. Each word is presented for one cycle on a simple write port, so the surrounding logic can store it. A status flag then reports that the part is programmed. The low byte of the signature word is kept as a checksum that software can read.

When the signature does not match, the part is taken to be blank and the flag stays clear. Software can then ask for the pins. It writes the load bit while the flag is clear, and the block enters a bypass mode. In that mode three writable control bits drive chip select, serial clock and data-in, and a readable bit returns the sampled data-out line. This lets software program a blank part in place. When the flag is set, writing the load bit instead starts a new automatic load. Software polls the load bit until it reads zero.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: During and just after reset, the control register (host address 0) reads 0x01: load bit (bit 0) set, all other bits clear. No configuration write is issued, and an automatic load starts without any host action.
- R2: Each serial read holds chip select high for the whole frame. It then sends 1, 1, 0, followed by the 6-bit word address MSB first. The EEPROM takes each bit on a rising serial-clock edge.
- R3: While a frame is running, every serial-clock half period lasts exactly HALF_DIV system clock cycles. This includes the first half period after chip select rises.
- R4: After the address, the block captures 16 data bits MSB first, one at each of the next 16 rising serial-clock edges.
- R5: A load reads word 0x0F first. When its upper byte is 0x73, the block then reads words 0 to NUM_WORDS-1 in ascending order. Each word appears on cfg_data with cfg_addr equal to its index during a single-cycle cfg_we pulse.
- R6: When the upper byte of word 0x0F is not 0x73, no further word is read and cfg_we never pulses. The load bit clears and the programmed flag (control bit 4) reads 0.
- R7: The load bit clears in the cycle right after the last cfg_we pulse of a successful load. The programmed flag reads 1 from that same cycle.
- R8: Host address 1 returns the low byte of the most recently read word 0x0F.
- R9: When the block is idle with the flag clear, writing the load bit as 1 enters bypass mode, and control bit 6 reads 1. In bypass mode, control bits 1, 2 and 3 drive ee_cs, ee_sk and ee_di in the cycle after the write.
- R10: Control bit 5 returns ee_do as it was one clock earlier.
- R11: When the block is idle with the flag set, writing the load bit as 1 starts a new load. When idle, writing it as 0 leaves bypass mode. Outside a load and outside bypass mode, ee_cs, ee_sk and ee_di are all 0.
- R12: Writes to the load bit during a load have no effect, and the bit keeps reading 1 until the load ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | Host register select: 0 control, 1 checksum |
| host_wdata | input | 4 | Write data: bit 0 load, bit 1 cs, bit 2 sk, bit 3 di |
| host_rdata | output | 8 | Read data of the selected register |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| cfg_we | output | 1 | One-cycle strobe per loaded word |
| cfg_addr | output | clog2(NUM_WORDS) | Index of the loaded word |
| cfg_data | output | 16 | Loaded word |

## Verification
The assertions assume the host writes the control register only through the strobe. They also assume the word count keeps the final index reachable, so a last-word pulse always exists. The serial clock is taken as a divided system clock with no external skew, which lets its edges be counted in system cycles. The stimulus drives ee_do from a behavioural EEPROM that changes data only after falling serial-clock edges. The one exception is the bypass test, where the bench drives the line directly while no frame is running. Host writes come only at clock mid-cycle, and load-bit writes during a load are timed well inside the first frame.

// File: rtl/eeld_pkg.sv
`timescale 1ns/1ps
package eeld_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SIG, SQ_DATA, SQ_END} seq_e;
  typedef enum logic [1:0] {EN_IDLE, EN_RUN, EN_GAP} eng_e;
  localparam logic [2:0] RD_PREFIX = 3'b110;
  localparam int CB_LOAD = 0;
  localparam int CB_CS   = 1;
  localparam int CB_SK   = 2;
  localparam int CB_DI   = 3;
endpackage

// File: rtl/eeld_tick_gen.sv
`timescale 1ns/1ps
module eeld_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eeld_frame_eng.sv
`timescale 1ns/1ps
module eeld_frame_eng
  import eeld_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              do_in,
  output logic              busy,
  output logic              done,
  output logic              cs,
  output logic              sk,
  output logic              di,
  output logic [DATA_W-1:0] rdata
);
  localparam int CMD_W = 3 + ADDR_W;
  localparam int TOTAL = CMD_W + DATA_W;
  localparam int BW    = $clog2(TOTAL + 1);

  eng_e              st_q, st_d;
  logic              sk_q, sk_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;
  logic              tick;

  eeld_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (st_q != EN_IDLE),
    .tick (tick)
  );

  always_comb begin
    st_d   = st_q;
    sk_d   = sk_q;
    bit_d  = bit_q;
    cmd_d  = cmd_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    case (st_q)
      EN_IDLE: if (start) begin
        st_d  = EN_RUN;
        cmd_d = {RD_PREFIX, addr};
        bit_d = '0;
        sk_d  = 1'b0;
      end
      EN_RUN: if (tick) begin
        if (!sk_q) begin
          sk_d = 1'b1;
          if (bit_q >= BW'(CMD_W)) sh_d = {sh_q[DATA_W-2:0], do_in};
        end else begin
          sk_d  = 1'b0;
          cmd_d = cmd_q << 1;
          if (bit_q == BW'(TOTAL - 1)) begin
            st_d  = EN_GAP;
            bit_d = '0;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      EN_GAP: if (tick) begin
        st_d   = EN_IDLE;
        done_d = 1'b1;
      end
      default: st_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_IDLE;
      sk_q   <= 1'b0;
      bit_q  <= '0;
      cmd_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sk_q   <= sk_d;
      bit_q  <= bit_d;
      cmd_q  <= cmd_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  assign busy  = (st_q != EN_IDLE);
  assign done  = done_q;
  assign cs    = (st_q == EN_RUN);
  assign sk    = sk_q;
  assign di    = cs & cmd_q[CMD_W-1];
  assign rdata = sh_q;
endmodule

// File: rtl/eeld_sequencer.sv
`timescale 1ns/1ps
module eeld_sequencer
  import eeld_pkg::*;
#(
  parameter int              ADDR_W    = 6,
  parameter int              DATA_W    = 16,
  parameter int              NUM_WORDS = 4,
  parameter logic [ADDR_W-1:0] SIG_ADDR = 'h0F,
  parameter logic [7:0]      SIG_BYTE  = 8'h73
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_wr,
  input  logic                         load_val,
  input  logic                         eng_busy,
  input  logic                         eng_done,
  input  logic [DATA_W-1:0]            eng_data,
  output logic                         eng_start,
  output logic [ADDR_W-1:0]            eng_addr,
  output logic                         busy,
  output logic                         load_bit,
  output logic                         prog_flag,
  output logic [7:0]                   csum,
  output logic                         we,
  output logic [$clog2(NUM_WORDS)-1:0] waddr,
  output logic [DATA_W-1:0]            wdata
);
  localparam int IW = $clog2(NUM_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WORDS - 1);

  seq_e              st_q, st_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              pass_q, pass_d;
  logic              load_q, load_d;
  logic              flag_q, flag_d;
  logic [7:0]        csum_q, csum_d;
  logic              we_q, we_d;
  logic [IW-1:0]     waddr_q, waddr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    pass_d  = pass_q;
    load_d  = load_q;
    flag_d  = flag_q;
    csum_d  = csum_q;
    we_d    = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    case (st_q)
      SQ_IDLE: if (load_wr) begin
        load_d = load_val;
        if (load_val && flag_q) st_d = SQ_SIG;
      end
      SQ_SIG: if (eng_done) begin
        csum_d = eng_data[7:0];
        if (eng_data[DATA_W-1 -: 8] == SIG_BYTE) begin
          st_d  = SQ_DATA;
          idx_d = '0;
        end else begin
          pass_d = 1'b0;
          st_d   = SQ_END;
        end
      end
      SQ_DATA: if (eng_done) begin
        we_d    = 1'b1;
        waddr_d = idx_q;
        wdata_d = eng_data;
        if (idx_q == LAST_IDX) begin
          pass_d = 1'b1;
          st_d   = SQ_END;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      SQ_END: begin
        load_d = 1'b0;
        flag_d = pass_q;
        st_d   = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_SIG;
      idx_q   <= '0;
      pass_q  <= 1'b0;
      load_q  <= 1'b1;
      flag_q  <= 1'b0;
      csum_q  <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      pass_q  <= pass_d;
      load_q  <= load_d;
      flag_q  <= flag_d;
      csum_q  <= csum_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign eng_start = ((st_q == SQ_SIG) || (st_q == SQ_DATA)) && !eng_busy && !eng_done;
  assign eng_addr  = (st_q == SQ_SIG) ? SIG_ADDR : ADDR_W'(idx_q);
  assign busy      = (st_q != SQ_IDLE);
  assign load_bit  = load_q;
  assign prog_flag = flag_q;
  assign csum      = csum_q;
  assign we        = we_q;
  assign waddr     = waddr_q;
  assign wdata     = wdata_q;
endmodule

// File: rtl/eeprom_cfg_loader.sv
`timescale 1ns/1ps
module eeprom_cfg_loader
  import eeld_pkg::*;
#(
  parameter int                HALF_DIV  = 2,
  parameter int                ADDR_W    = 6,
  parameter int                DATA_W    = 16,
  parameter int                NUM_WORDS = 4,
  parameter logic [ADDR_W-1:0] SIG_ADDR  = 'h0F,
  parameter logic [7:0]        SIG_BYTE  = 8'h73
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_wr,
  input  logic                         host_addr,
  input  logic [3:0]                   host_wdata,
  output logic [7:0]                   host_rdata,
  output logic                         ee_cs,
  output logic                         ee_sk,
  output logic                         ee_di,
  input  logic                         ee_do,
  output logic                         cfg_we,
  output logic [$clog2(NUM_WORDS)-1:0] cfg_addr,
  output logic [DATA_W-1:0]            cfg_data
);
  localparam int IW = $clog2(NUM_WORDS);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              ctrl_wr;
  logic              eng_start, eng_busy, eng_done;
  logic              eng_cs, eng_sk, eng_di;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_data;
  logic              seq_busy, load_bit, prog_flag, direct_mode;
  logic [7:0]        csum;
  logic              pin_cs_q, pin_sk_q, pin_di_q;
  logic              pin_cs_d, pin_sk_d, pin_di_d;
  logic              do_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign ctrl_wr = host_wr && (host_addr == 1'b0);

  eeld_frame_eng #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .HALF_DIV(HALF_DIV)
  ) u_eng (
    .clk  (clk),
    .rst_n(rst_n_int),
    .start(eng_start),
    .addr (eng_addr),
    .do_in(ee_do),
    .busy (eng_busy),
    .done (eng_done),
    .cs   (eng_cs),
    .sk   (eng_sk),
    .di   (eng_di),
    .rdata(eng_data)
  );

  eeld_sequencer #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_WORDS(NUM_WORDS),
    .SIG_ADDR (SIG_ADDR),
    .SIG_BYTE (SIG_BYTE)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load_wr  (ctrl_wr),
    .load_val (host_wdata[CB_LOAD]),
    .eng_busy (eng_busy),
    .eng_done (eng_done),
    .eng_data (eng_data),
    .eng_start(eng_start),
    .eng_addr (eng_addr),
    .busy     (seq_busy),
    .load_bit (load_bit),
    .prog_flag(prog_flag),
    .csum     (csum),
    .we       (cfg_we),
    .waddr    (cfg_addr),
    .wdata    (cfg_data)
  );

  always_comb begin
    pin_cs_d = pin_cs_q;
    pin_sk_d = pin_sk_q;
    pin_di_d = pin_di_q;
    if (ctrl_wr) begin
      pin_cs_d = host_wdata[CB_CS];
      pin_sk_d = host_wdata[CB_SK];
      pin_di_d = host_wdata[CB_DI];
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      pin_cs_q <= 1'b0;
      pin_sk_q <= 1'b0;
      pin_di_q <= 1'b0;
      do_q     <= 1'b0;
    end else begin
      pin_cs_q <= pin_cs_d;
      pin_sk_q <= pin_sk_d;
      pin_di_q <= pin_di_d;
      do_q     <= ee_do;
    end
  end

  assign direct_mode = !seq_busy && load_bit && !prog_flag;

  assign ee_cs = seq_busy ? eng_cs : (direct_mode & pin_cs_q);
  assign ee_sk = seq_busy ? eng_sk : (direct_mode & pin_sk_q);
  assign ee_di = seq_busy ? eng_di : (direct_mode & pin_di_q);

  assign host_rdata = host_addr ? csum
                    : {1'b0, direct_mode, do_q, prog_flag, pin_di_q, pin_sk_q, pin_cs_q, load_bit};
endmodule

// File: rtl/eeld_checks.sv
`timescale 1ns/1ps
module eeld_checks #(
  parameter int NUM_WORDS = 4,
  parameter int IW        = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ee_cs,
  input logic          ee_sk,
  input logic          ee_di,
  input logic          cfg_we,
  input logic [IW-1:0] cfg_addr,
  input logic          seq_busy,
  input logic          direct_mode,
  input logic          load_bit,
  input logic          prog_flag
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WORDS - 1);

  a_r2_sk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && ee_sk) |-> ee_cs);

  a_r5_we_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !cfg_we);

  a_r7_flag_after_last_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == LAST_IDX) |=> (!load_bit && prog_flag));

  a_r11_quiet_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !direct_mode) |-> (!ee_cs && !ee_sk && !ee_di));

  a_r12_load_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> load_bit);
endmodule

bind eeprom_cfg_loader eeld_checks #(
  .NUM_WORDS(NUM_WORDS),
  .IW       (IW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .ee_cs      (ee_cs),
  .ee_sk      (ee_sk),
  .ee_di      (ee_di),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .seq_busy   (seq_busy),
  .direct_mode(direct_mode),
  .load_bit   (load_bit),
  .prog_flag  (prog_flag)
);

// File: tb/eeprom_cfg_loader_test.sv
`timescale 1ns/1ps
module eeprom_cfg_loader_test;
  localparam int HALF = 2;
  localparam int NW   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_addr = 1'b0;
  logic [3:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       ee_cs, ee_sk, ee_di, ee_do;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [15:0] cfg_data;

  logic        model_do = 1'b0;
  logic        force_do = 1'b0;
  logic        bench_do = 1'b0;
  logic [15:0] mem [0:63];

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_bits = 0, m_dbits = 0, last_edge = 0, per_bad = 0, auto_chk = 1;
  logic [8:0] m_cmd = '0;
  logic       cs_prev = 1'b0, sk_prev = 1'b0, ld_prev = 1'b0;
  logic [8:0] cmd_log [0:15];
  int cmd_n = 0, wr_n = 0, last_we = -100, clr_cyc = -1;
  logic [1:0]  wr_a [0:7];
  logic [15:0] wr_d [0:7];
  logic flag_at_clr = 1'b0;

  always #2.5 clk = ~clk;
  assign ee_do = force_do ? bench_do : model_do;

  eeprom_cfg_loader #(.HALF_DIV(HALF), .NUM_WORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ee_cs(ee_cs),
    .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural serial EEPROM plus port monitors, evaluated mid-cycle.
  always @(negedge clk) begin
    if (ee_cs && !cs_prev) begin
      m_bits = 0; m_dbits = 0; model_do = 1'b0; last_edge = cyc;
    end else if (ee_cs && (ee_sk != sk_prev)) begin
      if (auto_chk != 0 && (cyc - last_edge) != HALF) per_bad++;
      last_edge = cyc;
      if (ee_sk) begin
        if (m_bits < 9) begin
          m_cmd = {m_cmd[7:0], ee_di};
          m_bits++;
          if (m_bits == 9 && cmd_n < 16) begin cmd_log[cmd_n] = m_cmd; cmd_n++; end
        end
      end else if (m_bits == 9 && m_dbits < 16) begin
        model_do = mem[m_cmd[5:0]][15 - m_dbits];
        m_dbits++;
      end
    end
    if (!ee_cs) model_do = 1'b0;
    cs_prev = ee_cs;
    sk_prev = ee_sk;
    if (cfg_we) begin
      if (wr_n < 8) begin wr_a[wr_n] = cfg_addr; wr_d[wr_n] = cfg_data; end
      wr_n++;
      last_we = cyc;
    end
    if (host_addr == 1'b0) begin
      if (ld_prev && !host_rdata[0]) begin clr_cyc = cyc; flag_at_clr = host_rdata[4]; end
      ld_prev = host_rdata[0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [3:0] d);
    @(negedge clk);
    #1 host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    #1 host_wr = 1'b0; host_addr = 1'b0;
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    #1 host_addr = a;
    #1 d = host_rdata;
    host_addr = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      #1;
      if (!host_rdata[0]) break;
    end
  endtask

  task automatic fill_mem(input bit good);
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    if (good) mem[15][15:8] = 8'h73;
    else      mem[15][15:8] = 8'h73 ^ 8'(1 + ($urandom % 255));
  endtask

  task automatic clear_logs();
    cmd_n = 0; wr_n = 0; last_we = -100; clr_cyc = -1; flag_at_clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_load(input bit good);
    logic [7:0] rd;
    chk("R2 signature command", {23'd0, cmd_log[0]}, {23'd0, 3'b110, 6'h0F});
    if (good) begin
      chk("R5 frame count", cmd_n, NW + 1);
      for (int i = 0; i < NW; i++)
        chk("R2 word command", {23'd0, cmd_log[i+1]}, {23'd0, 3'b110, 6'(i)});
      chk("R5 write count", wr_n, NW);
      for (int i = 0; i < NW; i++) begin
        chk("R5 write index", {30'd0, wr_a[i]}, i);
        chk("R4 word data", {16'd0, wr_d[i]}, {16'd0, mem[i]});
      end
      chk("R7 load clear timing", clr_cyc, last_we + 1);
      chk("R7 flag set", {31'd0, flag_at_clr}, 1);
    end else begin
      chk("R6 single frame", cmd_n, 1);
      chk("R6 no writes", wr_n, 0);
      chk("R6 load cleared", {31'd0, (clr_cyc >= 0)}, 1);
      chk("R6 flag clear", {31'd0, flag_at_clr}, 0);
    end
    host_read(1'b1, rd);
    chk("R8 checksum", {24'd0, rd}, {24'd0, mem[15][7:0]});
    chk("R3 half period", per_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [2:0] r;
    bit good;
    void'($urandom(32'd4242));

    // R1: reset state and automatic start
    fill_mem(1'b1);
    clear_logs();
    do_reset();
    host_read(1'b0, rd);
    chk("R1 control after reset", {24'd0, rd}, 32'h01);
    chk("R1 no write at reset", {31'd0, cfg_we}, 0);
    wait_done();
    check_load(1'b1);

    // R11: reload when the flag is set
    fill_mem(1'b1);
    clear_logs();
    host_write(1'b0, 4'b0001);
    wait_done();
    check_load(1'b1);

    // R6: blank part
    fill_mem(1'b0);
    clear_logs();
    host_write(1'b0, 4'b0001);
    wait_done();
    check_load(1'b0);

    // R9: bypass mode
    auto_chk = 0;
    host_write(1'b0, 4'b0001);
    host_read(1'b0, rd);
    chk("R9 bypass indicated", {31'd0, rd[6]}, 1);
    for (int i = 0; i < 6; i++) begin
      r = 3'($urandom % 8);
      host_write(1'b0, {r[2], r[1], r[0], 1'b1});
      chk("R9 cs pin", {31'd0, ee_cs}, {31'd0, r[0]});
      chk("R9 sk pin", {31'd0, ee_sk}, {31'd0, r[1]});
      chk("R9 di pin", {31'd0, ee_di}, {31'd0, r[2]});
    end

    // R10: data-out sampling
    force_do = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bench_do = (i % 2 == 0) ? 1'b1 : 1'b0;
      @(negedge clk);
      host_read(1'b0, rd);
      chk("R10 do bit", {31'd0, rd[5]}, {31'd0, bench_do});
    end

    // R11: leave bypass, pins quiet even with pin bits set
    host_write(1'b0, 4'b1110);
    chk("R11 quiet cs", {31'd0, ee_cs}, 0);
    chk("R11 quiet sk", {31'd0, ee_sk}, 0);
    chk("R11 quiet di", {31'd0, ee_di}, 0);
    host_read(1'b0, rd);
    chk("R11 bypass left", {31'd0, rd[6]}, 0);
    force_do = 1'b0;
    auto_chk = 1;

    // R12: load-bit write ignored during a load
    fill_mem(1'b1);
    clear_logs();
    do_reset();
    repeat (30) @(negedge clk);
    host_write(1'b0, 4'b0000);
    host_read(1'b0, rd);
    chk("R12 load bit held", {31'd0, rd[0]}, 1);
    wait_done();
    check_load(1'b1);

    // Random rounds: R5 / R6 mixed
    for (int k = 0; k < 4; k++) begin
      good = ($urandom % 2) == 1;
      fill_mem(good);
      clear_logs();
      do_reset();
      wait_done();
      check_load(good);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule